// File: doc/BRIEF.md
# Host/processor shared memory arbiter

This block shares one synchronous memory bus between two masters: a card-side host I/O port and an embedded processor. Behind the bus are a slow program memory, which only the processor reaches, and a data SRAM, which both masters reach. A host write is taken into a single-entry posted buffer and the host cycle ends at once. A host read always goes to SRAM. The host is held off with an active-low WAIT until the read data is available.

The bus is granted by turns. When the last access went to the processor, host-side work goes first, and the posted write goes before the held read. When the last access went to host-side work, a requesting processor goes first. Each access lasts one clock plus a wait-state count chosen by its target, with a separate count for program memory and for SRAM. Host strobes are asynchronous to the block clock. They pass through a two-flop synchroniser, and a cycle starts on the falling edge of the synchronised strobe. Address, data, CE and REG are sampled at that point.

The processor holds `procReq` and its address, direction and target steady until it sees `procDone`. Read data is valid on `procRdata` in that same cycle. The memory port keeps `memReq` high for the whole access, and `memLast` marks the final cycle. A write takes effect on the edge that ends the `memLast` cycle, and read data is taken from `memRdata` during `memLast`.

Top module: `hostProcMemArb`

## Requirements
- R1: After reset, `hostWaitN` and `hostInpackN` are high, and `memReq`, `procGnt` and `hostRdataOe` are low.
- R2: A host write strobe with CE and REG low is posted when the buffer is empty, with no WAIT. A later host read of the same address returns the written data.
- R3: A host read with CE and REG low drives `hostWaitN` low from the edge where it is detected until its SRAM read completes. The read data is on `hostRdata` in the first cycle where `hostWaitN` is high again.
- R4: A pending posted write takes the bus right after a processor access ends, and it reaches SRAM before any later host read.
- R5: When a posted-write access ends and the processor is requesting, the processor gets the next access ahead of a waiting host read. With both wait-state counts at 3, a read detected on the edge that ends a processor program fetch, with a write pending and the processor requesting without pause, sees `hostWaitN` low for 12 cycles.
- R6: A granted access keeps `memReq` high for `1 + ws` cycles. `ws` is `progWs` for processor program-memory accesses and `sramWs` for every SRAM access, each from 0 to 3.
- R7: `hostInpackN` is low and `hostRdataOe` is high exactly while `hostIordN`, `hostRegN` and `hostCeN` are all low, and `hostRdata` is zero otherwise.
- R8: A host write that arrives while the posted buffer is still occupied is held with `hostWaitN` low until the buffer drains. The write is then accepted and lands in SRAM.
- R9: A host strobe with CE or REG high is ignored: no WAIT, no memory access, and SRAM is left unchanged.
- R10: A processor access returns memory data on `procRdata` with a one-cycle `procDone` pulse at its end. A processor SRAM write is visible to later host reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| progWs | input | WSW | Extra wait clocks for program memory |
| sramWs | input | WSW | Extra wait clocks for SRAM |
| hostIordN | input | 1 | Host I/O read strobe, active low |
| hostIowrN | input | 1 | Host I/O write strobe, active low |
| hostRegN | input | 1 | Host register-space select, active low |
| hostCeN | input | 1 | Host card enable, active low |
| hostAddr | input | AW | Host address |
| hostWdata | input | DW | Host write data |
| hostRdata | output | DW | Host read data, zero when not enabled |
| hostRdataOe | output | 1 | Host data output enable |
| hostInpackN | output | 1 | Input acknowledge, active low |
| hostWaitN | output | 1 | Host wait, active low |
| procReq | input | 1 | Processor access request |
| procWe | input | 1 | Processor write when high |
| procToProg | input | 1 | Processor targets program memory when high |
| procAddr | input | AW | Processor address |
| procWdata | input | DW | Processor write data |
| procRdata | output | DW | Processor read data, valid with procDone |
| procGnt | output | 1 | Processor owns the bus |
| procDone | output | 1 | Final cycle of a processor access |
| memReq | output | 1 | Memory access active |
| memLast | output | 1 | Final cycle of the memory access |
| memWe | output | 1 | Memory write |
| memSelProg | output | 1 | Selects program memory over SRAM |
| memAddr | output | AW | Memory address |
| memWdata | output | DW | Memory write data |
| memRdata | input | DW | Memory read data |

## Verification
The hardest case to reach is a host read that lands while a posted write is pending and the processor is partway through a program fetch. Only that alignment shows the full processor, write, processor, read sequence. The bench reaches it with directed strobes placed at fixed clock offsets from a held processor request, so that read detection falls on the edge that ends the fetch. A similar placement brings a second write in while the first is still draining. Randomised runs then overlap processor fetches with host traffic under random wait-state settings.

// File: rtl/smArbPkg.sv
package smArbPkg;

  // Current or selected owner of the shared memory bus
  typedef enum logic [1:0] {
    OWN_PROC = 2'd0,
    OWN_PW   = 2'd1,
    OWN_RD   = 2'd2
  } ownerE;

  // Strobes from control to datapath
  typedef struct packed {
    logic  capHost;   // latch host address/data at cycle start
    logic  pwLoad;    // load posted-write buffer
    logic  accStart;  // launch a memory access
    ownerE accOwner;  // who the launched access belongs to
    logic  rdDone;    // host read completes, latch its data
  } dpCtrlT;

endpackage

// File: rtl/smArbCtrl.sv
module smArbCtrl
  import smArbPkg::*;
#(
  parameter int WSW         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           hostIordN,
  input  logic           hostIowrN,
  input  logic           hostRegN,
  input  logic           hostCeN,
  input  logic           procReq,
  input  logic           procToProg,
  input  logic [WSW-1:0] progWs,
  input  logic [WSW-1:0] sramWs,
  output dpCtrlT         ctrl,
  output logic           memReq,
  output logic           memLast,
  output logic           procGnt,
  output logic           procDone,
  output logic           hostWaitN
);

  localparam int NSTB = 2;  // index 0: read strobe, index 1: write strobe

  logic [NSTB-1:0] strobeRaw;
  logic [NSTB-1:0] fallSeen;
  assign strobeRaw = {hostIowrN, hostIordN};

  // Strobe synchronisers with falling-edge detect
  for (genvar g = 0; g < NSTB; g++) begin : gSync
    logic [SYNC_STAGES:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-1:0], strobeRaw[g]};
    end
    assign fallSeen[g] = !chain[SYNC_STAGES-1] && chain[SYNC_STAGES];
  end

  logic hostSel, rdStart, wrStart;
  assign hostSel = !hostCeN && !hostRegN;
  assign rdStart = fallSeen[0] && hostSel;
  assign wrStart = fallSeen[1] && hostSel;

  // Bus state
  logic           busy;
  ownerE          owner;
  logic [WSW-1:0] cnt;
  logic           lastWasProc;
  logic           pwValid, wrHeld, rdPend;

  logic lastCycle, freeNow;
  logic procEnds, pwEnds, rdEnds;
  assign lastCycle = busy && (cnt == '0);
  assign freeNow   = !busy || lastCycle;
  assign procEnds  = lastCycle && (owner == OWN_PROC);
  assign pwEnds    = lastCycle && (owner == OWN_PW);
  assign rdEnds    = lastCycle && (owner == OWN_RD);

  // A requester whose access is ending this cycle is not regranted at once
  logic rqProc, rqPw, rqRd;
  assign rqProc = procReq && !procEnds;
  assign rqPw   = pwValid && !pwEnds;
  assign rqRd   = rdPend  && !rdEnds;

  ownerE          win;
  logic           haveWin;
  logic [WSW-1:0] wsNext;

  always_comb begin
    win     = OWN_PROC;
    haveWin = 1'b1;
    if (lastWasProc) begin
      if (rqPw)        win = OWN_PW;
      else if (rqRd)   win = OWN_RD;
      else if (rqProc) win = OWN_PROC;
      else             haveWin = 1'b0;
    end else begin
      if (rqProc)      win = OWN_PROC;
      else if (rqPw)   win = OWN_PW;
      else if (rqRd)   win = OWN_RD;
      else             haveWin = 1'b0;
    end
    wsNext = ((win == OWN_PROC) && procToProg) ? progWs : sramWs;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      owner       <= OWN_PROC;
      cnt         <= '0;
      lastWasProc <= 1'b0;
    end else if (freeNow) begin
      if (haveWin) begin
        busy        <= 1'b1;
        owner       <= win;
        cnt         <= wsNext;
        lastWasProc <= (win == OWN_PROC);
      end else begin
        busy <= 1'b0;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // Host-side bookkeeping of posted write, held write and waiting read
  logic acceptNow;
  assign acceptNow = wrStart && (!pwValid || pwEnds);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwValid <= 1'b0;
      wrHeld  <= 1'b0;
      rdPend  <= 1'b0;
    end else begin
      if (acceptNow || (wrHeld && pwEnds)) pwValid <= 1'b1;
      else if (pwEnds)                     pwValid <= 1'b0;

      if (wrStart && pwValid && !pwEnds) wrHeld <= 1'b1;
      else if (pwEnds)                   wrHeld <= 1'b0;

      if (rdStart)     rdPend <= 1'b1;
      else if (rdEnds) rdPend <= 1'b0;
    end
  end

  always_comb begin
    ctrl.capHost  = rdStart || wrStart;
    ctrl.pwLoad   = acceptNow || (wrHeld && pwEnds);
    ctrl.accStart = freeNow && haveWin;
    ctrl.accOwner = win;
    ctrl.rdDone   = rdEnds;
  end

  assign memReq    = busy;
  assign memLast   = lastCycle;
  assign procGnt   = busy && (owner == OWN_PROC);
  assign procDone  = procEnds;
  assign hostWaitN = !(rdPend || wrHeld);

  // R6
  wsCount_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> (busy && $stable(owner) && cnt == $past(cnt) - 1'b1));

  // R4
  pwAfterProc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procEnds && pwValid) |=> (busy && owner == OWN_PW));

  // R5
  procAfterPw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwEnds && procReq) |=> (busy && owner == OWN_PROC));

  // R3
  waitRelease_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostWaitN) |-> ($past(rdEnds) || $past(wrHeld && pwEnds)));

  // R8
  heldStays_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrHeld && !pwEnds) |=> (wrHeld && !hostWaitN));

endmodule

// File: rtl/smArbDatapath.sv
module smArbDatapath
  import smArbPkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrlT        ctrl,
  input  logic          hostIordN,
  input  logic          hostRegN,
  input  logic          hostCeN,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  input  logic          procWe,
  input  logic          procToProg,
  input  logic [AW-1:0] procAddr,
  input  logic [DW-1:0] procWdata,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic          memWe,
  output logic          memSelProg,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] procRdata,
  output logic [DW-1:0] hostRdata,
  output logic          hostRdataOe,
  output logic          hostInpackN
);

  logic [AW-1:0] capAddr, pwAddr;
  logic [DW-1:0] capData, pwData, rdQ;
  logic [AW-1:0] wrSrcAddr;
  logic [DW-1:0] wrSrcData;

  // A write accepted on its start edge comes from the pins, a held one from capture
  assign wrSrcAddr = ctrl.capHost ? hostAddr  : capAddr;
  assign wrSrcData = ctrl.capHost ? hostWdata : capData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr <= '0;
      capData <= '0;
      pwAddr  <= '0;
      pwData  <= '0;
      rdQ     <= '0;
    end else begin
      if (ctrl.capHost) begin
        capAddr <= hostAddr;
        capData <= hostWdata;
      end
      if (ctrl.pwLoad) begin
        pwAddr <= wrSrcAddr;
        pwData <= wrSrcData;
      end
      if (ctrl.rdDone) rdQ <= memRdata;
    end
  end

  // Memory command register, loaded when an access launches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr    <= '0;
      memWe      <= 1'b0;
      memSelProg <= 1'b0;
      memWdata   <= '0;
    end else if (ctrl.accStart) begin
      unique case (ctrl.accOwner)
        OWN_PROC: begin
          memAddr    <= procAddr;
          memWe      <= procWe;
          memSelProg <= procToProg;
          memWdata   <= procWdata;
        end
        OWN_PW: begin
          memAddr    <= pwAddr;
          memWe      <= 1'b1;
          memSelProg <= 1'b0;
          memWdata   <= pwData;
        end
        default: begin
          memAddr    <= capAddr;
          memWe      <= 1'b0;
          memSelProg <= 1'b0;
          memWdata   <= '0;
        end
      endcase
    end
  end

  assign procRdata   = memRdata;
  assign hostInpackN = hostIordN || hostRegN || hostCeN;
  assign hostRdataOe = !hostInpackN;
  assign hostRdata   = hostRdataOe ? rdQ : '0;

  // R4
  pwWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.accStart && ctrl.accOwner == OWN_PW) |=> (memWe && !memSelProg));

endmodule

// File: rtl/hostProcMemArb.sv
module hostProcMemArb
  import smArbPkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int WSW = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [WSW-1:0] progWs,
  input  logic [WSW-1:0] sramWs,
  input  logic           hostIordN,
  input  logic           hostIowrN,
  input  logic           hostRegN,
  input  logic           hostCeN,
  input  logic [AW-1:0]  hostAddr,
  input  logic [DW-1:0]  hostWdata,
  output logic [DW-1:0]  hostRdata,
  output logic           hostRdataOe,
  output logic           hostInpackN,
  output logic           hostWaitN,
  input  logic           procReq,
  input  logic           procWe,
  input  logic           procToProg,
  input  logic [AW-1:0]  procAddr,
  input  logic [DW-1:0]  procWdata,
  output logic [DW-1:0]  procRdata,
  output logic           procGnt,
  output logic           procDone,
  output logic           memReq,
  output logic           memLast,
  output logic           memWe,
  output logic           memSelProg,
  output logic [AW-1:0]  memAddr,
  output logic [DW-1:0]  memWdata,
  input  logic [DW-1:0]  memRdata
);

  dpCtrlT ctrl;

  smArbCtrl #(.WSW(WSW), .SYNC_STAGES(2)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostIordN  (hostIordN),
    .hostIowrN  (hostIowrN),
    .hostRegN   (hostRegN),
    .hostCeN    (hostCeN),
    .procReq    (procReq),
    .procToProg (procToProg),
    .progWs     (progWs),
    .sramWs     (sramWs),
    .ctrl       (ctrl),
    .memReq     (memReq),
    .memLast    (memLast),
    .procGnt    (procGnt),
    .procDone   (procDone),
    .hostWaitN  (hostWaitN)
  );

  smArbDatapath #(.AW(AW), .DW(DW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .hostIordN   (hostIordN),
    .hostRegN    (hostRegN),
    .hostCeN     (hostCeN),
    .hostAddr    (hostAddr),
    .hostWdata   (hostWdata),
    .procWe      (procWe),
    .procToProg  (procToProg),
    .procAddr    (procAddr),
    .procWdata   (procWdata),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWe       (memWe),
    .memSelProg  (memSelProg),
    .memWdata    (memWdata),
    .procRdata   (procRdata),
    .hostRdata   (hostRdata),
    .hostRdataOe (hostRdataOe),
    .hostInpackN (hostInpackN)
  );

endmodule

// File: tb/hostProcMemArb_tb.sv
module hostProcMemArb_tb;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    progWs = 2'd0, sramWs = 2'd0;
  logic          hostIordN = 1'b1, hostIowrN = 1'b1, hostRegN = 1'b0, hostCeN = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0;
  logic [DW-1:0] hostRdata;
  logic          hostRdataOe, hostInpackN, hostWaitN;
  logic          procReq = 1'b0, procWe = 1'b0, procToProg = 1'b0;
  logic [AW-1:0] procAddr = '0;
  logic [DW-1:0] procWdata = '0;
  logic [DW-1:0] procRdata;
  logic          procGnt, procDone, memReq, memLast, memWe, memSelProg;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  hostProcMemArb #(.AW(AW), .DW(DW), .WSW(2)) u_dut (
    .clk(clk), .rstN(rstN), .progWs(progWs), .sramWs(sramWs),
    .hostIordN(hostIordN), .hostIowrN(hostIowrN), .hostRegN(hostRegN), .hostCeN(hostCeN),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostRdataOe(hostRdataOe), .hostInpackN(hostInpackN), .hostWaitN(hostWaitN),
    .procReq(procReq), .procWe(procWe), .procToProg(procToProg), .procAddr(procAddr),
    .procWdata(procWdata), .procRdata(procRdata), .procGnt(procGnt), .procDone(procDone),
    .memReq(memReq), .memLast(memLast), .memWe(memWe), .memSelProg(memSelProg),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  // Memory models and expected SRAM image
  function automatic logic [DW-1:0] progVal(input logic [AW-1:0] a);
    return ({8'h00, a} * 16'h0101) ^ 16'h5a3c;
  endfunction

  function automatic logic [DW-1:0] sramInit(input int a);
    return 16'(a * 7 + 16'h1200);
  endfunction

  logic [DW-1:0] sram   [0:255];
  logic [DW-1:0] shadow [0:255];

  initial begin
    for (int i = 0; i < 256; i++) begin
      sram[i]   = sramInit(i);
      shadow[i] = sramInit(i);
    end
  end

  always @(posedge clk) if (memLast && memWe && !memSelProg) sram[memAddr] <= memWdata;
  assign memRdata = memSelProg ? progVal(memAddr) : sram[memAddr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic ce, input logic rg, output int waitCnt);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostCeN = ce; hostRegN = rg; hostIowrN = 1'b0;
    waitCnt = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (!hostWaitN) waitCnt++;
      else if (k >= 3) break;
    end
    hostIowrN = 1'b1;
    repeat (4) @(negedge clk);
    hostCeN = 1'b0; hostRegN = 1'b0;
  endtask

  task automatic hostRead(input logic [AW-1:0] a, input logic ce, input logic rg,
                          output logic [DW-1:0] d, output int waitCnt,
                          output logic oeIn, output logic inpIn, output logic oeOut);
    @(negedge clk);
    hostAddr = a; hostCeN = ce; hostRegN = rg; hostIordN = 1'b0;
    waitCnt = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (!hostWaitN) waitCnt++;
      else if (k >= 3) break;
    end
    d = hostRdata; oeIn = hostRdataOe; inpIn = hostInpackN;
    hostIordN = 1'b1;
    @(negedge clk);
    oeOut = hostRdataOe;
    repeat (3) @(negedge clk);
    hostCeN = 1'b0; hostRegN = 1'b0;
  endtask

  task automatic procAccess(input logic [AW-1:0] a, input logic prog, input logic we,
                            input logic [DW-1:0] wd, output logic [DW-1:0] rd, output int gntCnt);
    @(negedge clk);
    procAddr = a; procToProg = prog; procWe = we; procWdata = wd; procReq = 1'b1;
    gntCnt = 0; rd = '0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (procGnt) gntCnt++;
      if (procDone) begin
        rd = procRdata;
        break;
      end
    end
    procReq = 1'b0;
  endtask

  task automatic stopProc();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (procDone) break;
    end
    procReq = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    logic oeIn, inpIn, oeOut;
    int w, g, waitLow, memSeen;
    void'($urandom(32'h5eed_0042));

    repeat (4) @(negedge clk);
    // R1: reset state
    check(hostWaitN == 1'b1 && hostInpackN == 1'b1, "R1 wait/inpack at reset", {hostWaitN, hostInpackN}, 3);
    check(!memReq && !procGnt && !hostRdataOe, "R1 bus idle at reset", {memReq, procGnt, hostRdataOe}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R2: posted write, no WAIT, then readback; R3 and R7 on the read
    hostWrite(8'h10, 16'hc0de, 1'b0, 1'b0, w);
    shadow[8'h10] = 16'hc0de;
    check(w == 0, "R2 posted write without wait", w, 0);
    hostRead(8'h10, 1'b0, 1'b0, rd, w, oeIn, inpIn, oeOut);
    check(rd == 16'hc0de, "R2 readback of posted write", rd, 16'hc0de);
    check(w > 0, "R3 read held with wait", w, 1);
    check(oeIn && !inpIn, "R7 oe/inpack during read strobe", {oeIn, inpIn}, 2);
    check(!oeOut && hostRdata == '0, "R7 output floats after strobe", {oeOut, hostRdata}, 0);

    // R6: access length per wait-state field
    for (int ws = 0; ws < 4; ws++) begin
      @(negedge clk);
      progWs = 2'(ws); sramWs = 2'(3 - ws);
      procAccess(8'(ws + 5), 1'b1, 1'b0, '0, rd, g);
      check(g == ws + 1, "R6 program memory access length", g, ws + 1);
      check(rd == progVal(8'(ws + 5)), "R10 processor program read data", rd, progVal(8'(ws + 5)));
      procAccess(8'h10, 1'b0, 1'b0, '0, rd, g);
      check(g == 4 - ws, "R6 SRAM access length", g, 4 - ws);
      check(rd == shadow[8'h10], "R10 processor SRAM read data", rd, shadow[8'h10]);
    end

    // R10: processor SRAM write seen by host
    procAccess(8'h40, 1'b0, 1'b1, 16'h7e57, rd, g);
    shadow[8'h40] = 16'h7e57;
    hostRead(8'h40, 1'b0, 1'b0, rd, w, oeIn, inpIn, oeOut);
    check(rd == 16'h7e57, "R10 processor write visible to host", rd, 16'h7e57);

    // R9: CE or REG inactive strobes ignored
    memSeen = 0;
    fork
      hostWrite(8'h10, 16'hdead, 1'b1, 1'b0, w);
      for (int k = 0; k < 10; k++) begin @(negedge clk); if (memReq) memSeen++; end
    join
    check(w == 0 && memSeen == 0, "R9 write with CE high ignored", w + memSeen, 0);
    hostWrite(8'h10, 16'hdead, 1'b0, 1'b1, w);
    check(w == 0, "R9 write with REG high no wait", w, 0);
    hostRead(8'h10, 1'b0, 1'b1, rd, w, oeIn, inpIn, oeOut);
    check(w == 0 && inpIn && !oeIn, "R9 R7 read with REG high ignored", {w[3:0], oeIn, inpIn}, 1);
    hostRead(8'h10, 1'b0, 1'b0, rd, w, oeIn, inpIn, oeOut);
    check(rd == shadow[8'h10], "R9 SRAM unchanged by ignored writes", rd, shadow[8'h10]);

    // R4 R5: worst-case ordering, both wait counts at 3
    @(negedge clk);
    progWs = 2'd3; sramWs = 2'd3;
    repeat (3) @(negedge clk);
    procAddr = 8'h21; procToProg = 1'b1; procWe = 1'b0; procReq = 1'b1;
    hostAddr = 8'h33; hostWdata = 16'hbeef; hostCeN = 1'b0; hostRegN = 1'b0; hostIowrN = 1'b0;
    shadow[8'h33] = 16'hbeef;
    @(negedge clk);
    @(negedge clk);
    hostIowrN = 1'b1; hostIordN = 1'b0;
    waitLow = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (!hostWaitN) waitLow++;
      else if (waitLow > 0) break;
    end
    rd = hostRdata;
    check(waitLow == 3 * (3 + 1), "R5 worst-case wait length", waitLow, 12);
    check(rd == 16'hbeef, "R4 read after pending write returns new data", rd, 16'hbeef);
    check(hostWaitN && hostRdataOe, "R3 data with wait release", {hostWaitN, hostRdataOe}, 3);
    hostIordN = 1'b1;
    stopProc();

    // R8: second write while buffer is occupied
    @(negedge clk);
    procAddr = 8'h22; procToProg = 1'b1; procReq = 1'b1;
    hostAddr = 8'h50; hostWdata = 16'h1111; hostIowrN = 1'b0;
    shadow[8'h50] = 16'h1111;
    @(negedge clk);
    @(negedge clk);
    hostIowrN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    hostAddr = 8'h51; hostWdata = 16'h2222; hostIowrN = 1'b0;
    shadow[8'h51] = 16'h2222;
    waitLow = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!hostWaitN) waitLow++;
      else if (waitLow > 0) break;
    end
    check(waitLow == 2, "R8 held write waits until buffer drains", waitLow, 2);
    hostIowrN = 1'b1;
    stopProc();
    hostRead(8'h50, 1'b0, 1'b0, rd, w, oeIn, inpIn, oeOut);
    check(rd == 16'h1111, "R8 first write landed", rd, 16'h1111);
    hostRead(8'h51, 1'b0, 1'b0, rd, w, oeIn, inpIn, oeOut);
    check(rd == 16'h2222, "R8 held write landed", rd, 16'h2222);

    // Random phase: processor fetches overlapping host traffic
    for (int it = 0; it < 40; it++) begin
      logic [AW-1:0] pa, ha;
      logic [DW-1:0] hd, prd, hrd;
      int pg, hw;
      bit doWrite;
      @(negedge clk);
      progWs = 2'($urandom_range(0, 3));
      sramWs = 2'($urandom_range(0, 3));
      pa = 8'($urandom_range(0, 255));
      ha = 8'($urandom_range(0, 15));
      hd = 16'($urandom);
      doWrite = 1'($urandom_range(0, 1));
      fork
        begin
          repeat ($urandom_range(0, 4)) @(negedge clk);
          procAccess(pa, 1'b1, 1'b0, '0, prd, pg);
          check(prd == progVal(pa), "R10 random processor fetch data", prd, progVal(pa));
        end
        begin
          if (doWrite) begin
            shadow[ha] = hd;
            hostWrite(ha, hd, 1'b0, 1'b0, hw);
          end else begin
            hostRead(ha, 1'b0, 1'b0, hrd, hw, oeIn, inpIn, oeOut);
            check(hrd == shadow[ha], "R4 random host read data", hrd, shadow[ha]);
          end
        end
      join
    end

    repeat (10) @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      hostRead(8'(a), 1'b0, 1'b0, rd, w, oeIn, inpIn, oeOut);
      check(rd == shadow[a], "R2 final SRAM image", rd, shadow[a]);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule